// File: doc/BRIEF.md
# SQE Heartbeat Test Generator

This block produces the signal-quality-error test burst that a twisted-pair transceiver sends toward its host after every good transmission. It watches the transmit-activity input for a high-to-low transition. If the heartbeat feature is enabled and the jabber flag is clear at that moment, it waits a fixed number of bit times. It then drives a square wave on the collision-pair output for a fixed number of bit times, and finally returns both the output and itself to idle.

Timing is measured in bit times, each `CLKS_PER_BIT` clocks long. With a 20 MHz clock and two clocks per bit, the waveform (one toggle per clock) is a 10 MHz tone. The default delay is 11 bit times and the default burst length is 10. If transmit activity comes back while the block is waiting or bursting, it drops straight back to idle. Real collision reports are merged with this output by an OR outside the block.

Top module: `sqe_heartbeat`

In the requirements, D = `DELAY_BITS` x `CLKS_PER_BIT` and B = `BURST_BITS` x `CLKS_PER_BIT`, both counted in clocks.

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, `busy` and `col_drive` are both 0. Asserting reset during a burst clears both outputs.
- R2: A falling edge of `tx_active` means it was sampled 1 at one rising clock edge and 0 at the next. When this edge is seen with `hb_enable`=1 and `jabber`=0, `busy` goes to 1 in the clock cycle that follows that edge.
- R3: `col_drive` stays 0 for the first D cycles of `busy` and is 1 in cycle D, counting the first busy cycle as cycle 0.
- R4: During the burst, `col_drive` starts at 1 and inverts every clock for B cycles, so it is high in ceil(B/2) of them.
- R5: After an undisturbed sequence, `busy` has been high for exactly D+B cycles, and then `busy` and `col_drive` are both 0.
- R6: A falling edge of `tx_active` seen while `hb_enable`=0 starts nothing: `busy` stays 0.
- R7: A falling edge of `tx_active` seen while `jabber`=1 starts nothing. `jabber` being high at other times, while it is low at the edge, does not prevent the burst.
- R8: If `tx_active` is 1 while `busy` is 1, `busy` and `col_drive` are 0 in the next cycle, and no remaining part of the burst is produced.
- R9: `col_drive` is never 1 while `busy` is 0.
- R10: Without a falling edge of `tx_active` (the line held high, or never raised), `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit time is `CLKS_PER_BIT` cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmit activity on the line, 1 while sending |
| hb_enable | input | 1 | Heartbeat feature enable, 1 = tests are produced |
| jabber | input | 1 | 1 while the jabber watchdog holds transmission off |
| col_drive | output | 1 | Collision-pair drive; square wave during the test burst |
| busy | output | 1 | 1 whenever the block is waiting or bursting |

## Verification
The bench builds the block with `CLKS_PER_BIT`=2, `DELAY_BITS`=3 and `BURST_BITS`=3, which gives a 6-cycle wait and a 6-cycle burst. These short windows keep every observation window small. They also make it easy to place an abort at chosen points: inside the wait, exactly on the wait-to-burst boundary, in the middle of the burst, and on the last burst cycle. An odd-free burst length still shows the alternating high and low pattern, and every expected count follows from D and B alone.

// File: rtl/sqe_hb_pkg.sv
package sqe_hb_pkg;

    typedef enum logic [1:0] {
        SQE_IDLE  = 2'd0,
        SQE_WAIT  = 2'd1,
        SQE_BURST = 2'd2
    } sqe_state_e;

endpackage

// File: rtl/sqe_txend_detect.sv
// Spots the end of a transmission and qualifies it for a heartbeat test.
module sqe_txend_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic hb_enable,
    input  logic jabber,
    output logic end_ok
);

    typedef struct packed {
        logic tx;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d    = det_q;
        det_d.tx = tx_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    // Falling edge of activity, heartbeat on, no jabber at that instant.
    assign end_ok = det_q.tx & ~tx_active & hb_enable & ~jabber;

endmodule

// File: rtl/sqe_bit_timer.sv
// Clock counter shared by the wait and burst windows.
module sqe_bit_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [WIDTH-1:0] limit,
    output logic             expired
);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.count = '0;
        end else if (tmr_q.count != limit) begin
            tmr_d.count = tmr_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.count == limit);

endmodule

// File: rtl/sqe_burst_wave.sv
// Square-wave source: starts high on entry, inverts every clock while running.
module sqe_burst_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic run,
    output logic wave
);

    typedef struct packed {
        logic level;
    } wav_t;

    wav_t wav_d, wav_q;

    always_comb begin
        wav_d = wav_q;
        if (enter) begin
            wav_d.level = 1'b1;
        end else if (run) begin
            wav_d.level = ~wav_q.level;
        end else begin
            wav_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wav_q <= '0;
        end else begin
            wav_q <= wav_d;
        end
    end

    assign wave = wav_q.level;

endmodule

// File: rtl/sqe_heartbeat.sv
module sqe_heartbeat
    import sqe_hb_pkg::*;
#(
    parameter int CLKS_PER_BIT = 2,
    parameter int DELAY_BITS   = 11,
    parameter int BURST_BITS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic hb_enable,
    input  logic jabber,
    output logic col_drive,
    output logic busy
);

    localparam int DLY_CLKS = DELAY_BITS * CLKS_PER_BIT;
    localparam int BST_CLKS = BURST_BITS * CLKS_PER_BIT;
    localparam int MAX_CLKS = (DLY_CLKS > BST_CLKS) ? DLY_CLKS : BST_CLKS;
    localparam int TW       = $clog2(MAX_CLKS + 1);

    typedef struct packed {
        sqe_state_e state;
    } ctl_t;

    ctl_t           ctl_d, ctl_q;
    logic           end_ok;
    logic           tmr_clear;
    logic           tmr_expired;
    logic [TW-1:0]  tmr_limit;
    logic           wave_enter;
    logic           wave_run;

    sqe_txend_detect u_txend (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .hb_enable (hb_enable),
        .jabber    (jabber),
        .end_ok    (end_ok)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.state)
            SQE_IDLE: begin
                if (end_ok) ctl_d.state = SQE_WAIT;
            end
            SQE_WAIT: begin
                if (tx_active)        ctl_d.state = SQE_IDLE;
                else if (tmr_expired) ctl_d.state = SQE_BURST;
            end
            SQE_BURST: begin
                if (tx_active || tmr_expired) ctl_d.state = SQE_IDLE;
            end
            default: ctl_d.state = SQE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: SQE_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tmr_clear = (ctl_q.state == SQE_IDLE) || (ctl_d.state != ctl_q.state);
    assign tmr_limit = (ctl_q.state == SQE_WAIT) ? TW'(DLY_CLKS - 1) : TW'(BST_CLKS - 1);

    sqe_bit_timer #(
        .WIDTH (TW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    assign wave_enter = (ctl_d.state == SQE_BURST) && (ctl_q.state != SQE_BURST);
    assign wave_run   = (ctl_d.state == SQE_BURST) && (ctl_q.state == SQE_BURST);

    sqe_burst_wave u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .enter (wave_enter),
        .run   (wave_run),
        .wave  (col_drive)
    );

    assign busy = (ctl_q.state != SQE_IDLE);

endmodule

// File: rtl/sqe_heartbeat_chk.sv
module sqe_heartbeat_chk #(
    parameter int CLKS_PER_BIT = 2,
    parameter int DELAY_BITS   = 11,
    parameter int BURST_BITS   = 10
) (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic hb_enable,
    input logic jabber,
    input logic col_drive,
    input logic busy
);

    localparam int DLY = DELAY_BITS * CLKS_PER_BIT;
    localparam int BST = BURST_BITS * CLKS_PER_BIT;

    int age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    age_q <= 0;
        else if (busy) age_q <= age_q + 1;
        else           age_q <= 0;
    end

    assert_col_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        col_drive |-> busy);

    assert_wave_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col_drive |=> !col_drive);

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_active) |=> (!busy && !col_drive));

    assert_hb_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hb_enable) |=> !busy);

    assert_jabber_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && jabber) |=> !busy);

    assert_quiet_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && age_q < DLY) |-> !col_drive);

    assert_burst_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && age_q == DLY) |-> col_drive);

    assert_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (age_q < DLY + BST));

endmodule

bind sqe_heartbeat sqe_heartbeat_chk #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .DELAY_BITS   (DELAY_BITS),
    .BURST_BITS   (BURST_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .hb_enable (hb_enable),
    .jabber    (jabber),
    .col_drive (col_drive),
    .busy      (busy)
);

// File: tb/sqe_heartbeat_bench.sv
`timescale 1ns/1ps
module sqe_heartbeat_bench;

    localparam int CPB = 2;
    localparam int DB  = 3;
    localparam int BB  = 3;
    localparam int D   = DB * CPB;
    localparam int B   = BB * CPB;
    localparam int WIN = D + B + 4;

    typedef struct packed {
        logic       hb;
        logic       jab;
        logic [7:0] tx_len;
        logic [7:0] abort_at;   // 0 = no abort
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{hb: 1'b1, jab: 1'b0, tx_len: 8'd5, abort_at: 8'd0},
        '{hb: 1'b0, jab: 1'b0, tx_len: 8'd4, abort_at: 8'd0},
        '{hb: 1'b1, jab: 1'b1, tx_len: 8'd4, abort_at: 8'd0},
        '{hb: 1'b1, jab: 1'b0, tx_len: 8'd1, abort_at: 8'd0},
        '{hb: 1'b1, jab: 1'b0, tx_len: 8'd3, abort_at: 8'd3},
        '{hb: 1'b1, jab: 1'b0, tx_len: 8'd3, abort_at: 8'd8},
        '{hb: 1'b1, jab: 1'b0, tx_len: 8'd2, abort_at: 8'd6},
        '{hb: 1'b1, jab: 1'b0, tx_len: 8'd2, abort_at: 8'd11}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0;
    logic hb_enable = 1'b0;
    logic jabber = 1'b0;
    logic col_drive;
    logic busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sqe_heartbeat #(
        .CLKS_PER_BIT (CPB),
        .DELAY_BITS   (DB),
        .BURST_BITS   (BB)
    ) u_sqe_heartbeat (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .hb_enable (hb_enable),
        .jabber    (jabber),
        .col_drive (col_drive),
        .busy      (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Quietly end a held transmission without triggering a test.
    task automatic silent_release();
        @(negedge clk);
        hb_enable = 1'b0;
        tx_active = 1'b0;
        cycles(3);
    endtask

    initial begin
        cycles(3);
        // R1: reset state
        check("R1 busy in reset", int'(busy), 0);
        check("R1 col in reset", int'(col_drive), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 col after reset", int'(col_drive), 0);

        for (int v = 0; v < NV; v++) begin
            vec_t   cv;
            string  tag;
            int     a;
            int     exp_busy;
            int     exp_high;
            int     exp_first;
            int     n_busy;
            int     n_high;
            int     first_col;
            int     first_busy;
            cv = VECS[v];
            a  = int'(cv.abort_at);
            if (!cv.hb)          tag = "R6";
            else if (cv.jab)     tag = "R7";
            else if (a != 0)     tag = "R8";
            else                 tag = "R5";
            if (!cv.hb || cv.jab) begin
                exp_busy = 0;
                exp_high = 0;
            end else begin
                exp_busy = (a == 0 || a > D + B) ? D + B : a;
                exp_high = (exp_busy > D) ? ((exp_busy - D) + 1) / 2 : 0;
            end
            exp_first = (exp_high > 0) ? D : -1;

            @(negedge clk);
            hb_enable = cv.hb;
            jabber    = cv.jab;
            tx_active = 1'b1;
            cycles(int'(cv.tx_len));
            tx_active = 1'b0;
            n_busy = 0; n_high = 0; first_col = -1; first_busy = 0;
            for (int i = 0; i < WIN; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (i == 0) first_busy = int'(busy);
                if (busy) n_busy++;
                if (col_drive) begin
                    n_high++;
                    if (first_col < 0) first_col = i;
                end
                if (a != 0 && i == a - 1) tx_active = 1'b1;
            end
            check({tag, " busy cycles"}, n_busy, exp_busy);
            check("R4 high cycles", n_high, exp_high);
            check("R3 first col cycle", first_col, exp_first);
            check("R2 busy right after edge", first_busy, (exp_busy > 0) ? 1 : 0);
            if (tx_active) silent_release();
            jabber    = 1'b0;
            hb_enable = 1'b0;
            cycles(2);
        end

        // R10: held transmission, no falling edge
        @(negedge clk);
        hb_enable = 1'b1;
        tx_active = 1'b1;
        cycles(30);
        check("R10 busy while tx held", int'(busy), 0);
        silent_release();
        // R10: line never active
        hb_enable = 1'b1;
        cycles(20);
        check("R10 busy with idle line", int'(busy), 0);

        // R7: jabber high during frame, low at the edge -> burst still runs
        @(negedge clk);
        tx_active = 1'b1;
        jabber = 1'b1;
        cycles(3);
        jabber = 1'b0;
        cycles(1);
        tx_active = 1'b0;
        cycles(D + 1);
        check("R7 burst after cleared jabber", int'(col_drive), 1);
        cycles(B + 2);
        check("R5 idle after burst", int'(busy), 0);

        // R1: reset in the middle of a burst
        @(negedge clk);
        tx_active = 1'b1;
        cycles(2);
        tx_active = 1'b0;
        cycles(D + 2);
        check("R4 mid-burst busy", int'(busy), 1);
        rst_n = 1'b0;
        #1;
        check("R1 busy cleared by reset", int'(busy), 0);
        check("R1 col cleared by reset", int'(col_drive), 0);
        cycles(2);
        rst_n = 1'b1;
        cycles(B + 2);
        check("R1 stays idle after reset", int'(busy), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule